// File: doc/BRIEF.md
# Multi-Source Interrupt Request Aggregator

This block gathers up to eight single-cycle event pulses from a peripheral into one level-sensitive interrupt request. Each event sets a sticky pending bit in a status register. A per-source enable register masks the pending bits. The masked bits are ORed together and registered into a request bit. A control register holds a 3-bit priority level next to the request bit, and the block forwards both to a CPU-side acceptance check.

The request bit is never latched on its own. It always follows the live pending-and-enabled set, one clock late. Software cannot write it. Taking the interrupt clears neither the request nor the status bits. The service routine reads the status register to find the cause. It then clears each pending bit by writing 0 to it, and that clear works only on a bit it has already read as 1.

Software reaches the registers over a simple bus. A write lands on the rising edge when `bus_wr_i` is high. Read data is combinational from `bus_addr_i`. A read updates the read-as-1 tracking when `bus_rd_i` is high at the rising edge. The bus has no handshake: every access completes in one cycle.

Top module: `irq_aggregator`

## Requirements
- R1: `irq_req_o` equals the OR over all sources of (status bit AND enable bit), registered, so it changes one clock after the status or enable registers update.
- R2: After reset, every register reads 0, and `irq_req_o` and `irq_accept_o` are 0.
- R3: A pulse on `evt_i[i]` sets status bit i at the next clock edge. Writing 1 to a status bit never sets it, and writing 1 never clears it.
- R4: Writing 0 to status bit i clears it only if a read of the status register (address 0) has returned that bit as 1 since it was last cleared. Otherwise the write leaves it unchanged.
- R5: If an event pulse on source i arrives in the same cycle as a valid clear of bit i, the bit stays 1. Its read-as-1 mark is dropped, so the next clear needs a new read.
- R6: Control register bit 3 is read-only and reflects `irq_req_o`. Writing 0 or 1 to it changes neither that bit nor `irq_req_o`.
- R7: A high `irq_accept_o` changes no register: the status bits and `irq_req_o` hold while the interrupt is being accepted.
- R8: `irq_accept_o` = `gie_i` AND `irq_req_o` AND (level > `cpu_ipl_i`), decided combinationally. Level 0 never produces acceptance.
- R9: While `irq_req_o` is 1, a further enabled source becoming pending, or the clearing of one of several enabled pending sources, does not drop `irq_req_o` to 0 in any cycle.
- R10: Enable bits are plain read/write bits at address 1. Setting the enable bit of an already pending source raises `irq_req_o` one clock after the write.
- R11: Register map: address 0 holds status in [7:0], address 1 holds enable in [7:0], and address 2 holds the level in [2:0] and the request in [3]. Bits [7:4] of address 2 and all of address 3 read 0. `irq_lvl_o` follows the level field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NSRC | Single-cycle event pulses, one per source |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (updates read-as-1 marks) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Combinational read data |
| gie_i | input | 1 | Global interrupt enable flag of the CPU |
| cpu_ipl_i | input | LVL_W | Current processor priority level |
| irq_req_o | output | 1 | Registered interrupt request |
| irq_lvl_o | output | LVL_W | Programmed priority level |
| irq_accept_o | output | 1 | Interrupt would be accepted by the CPU |

## Verification
The OR-of-AND function is swept over all 256 enable values for each of several pending patterns: none, the lowest source, the highest source, alternating and sparse masks, and all sources. Together these show whether every source lane is gated by its own enable and whether the OR covers the whole width. The acceptance decision is swept over every combination of flag, level and processor level, with the request both low and high. This separates the strict comparison from an inclusive one, and shows that level 0 stays off. The directed sequences cover the remaining cases: a clear without a prior read, an event arriving with a clear, writes to the read-only request bit, overlapping sources, and the exact one-cycle latency.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            rd_hit,
  input  logic            wr_hit,
  input  logic [NSRC-1:0] wdata,
  output logic [NSRC-1:0] status
);
  // One lane per source: a pending bit and its read-as-1 mark.
  for (genvar i = 0; i < NSRC; i++) begin : g_lane
    logic pend_q;
    logic seen_q;
    logic clr;

    always_comb clr = wr_hit & ~wdata[i] & seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        seen_q <= 1'b0;
      end else begin
        if (evt[i]) begin
          pend_q <= 1'b1;
        end else if (clr) begin
          pend_q <= 1'b0;
        end
        if (clr) begin
          seen_q <= 1'b0;
        end else if (rd_hit && pend_q) begin
          seen_q <= 1'b1;
        end
      end
    end

    assign status[i] = pend_q;
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NSRC-1:0]   status,
  input  logic              req,
  output logic [NSRC-1:0]   enable,
  output logic [LVL_W-1:0]  level,
  output logic [DATA_W-1:0] rdata,
  output logic              stat_rd_hit,
  output logic              stat_wr_hit
);
  localparam int REQ_BIT = LVL_W;

  reg_sel_e sel;
  logic     en_wr_hit;
  logic     ctl_wr_hit;

  always_comb begin
    sel         = reg_sel_e'(addr);
    stat_rd_hit = rd && (sel == SEL_STATUS);
    stat_wr_hit = wr && (sel == SEL_STATUS);
    en_wr_hit   = wr && (sel == SEL_ENABLE);
    ctl_wr_hit  = wr && (sel == SEL_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '0;
      level  <= '0;
    end else begin
      if (en_wr_hit)  enable <= wdata[NSRC-1:0];
      if (ctl_wr_hit) level  <= wdata[LVL_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_STATUS: rdata[NSRC-1:0] = status;
      SEL_ENABLE: rdata[NSRC-1:0] = enable;
      SEL_CTRL: begin
        rdata[LVL_W-1:0] = level;
        rdata[REQ_BIT]   = req;
      end
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] status,
  input  logic [NSRC-1:0] enable,
  output logic            req
);
  logic [NSRC-1:0] gated;

  always_comb gated = status & enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= |gated;
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept #(
  parameter int LVL_W = 3
) (
  input  logic             gie,
  input  logic             req,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] cpu_ipl,
  output logic             accept
);
  logic above;

  always_comb begin
    above  = level > cpu_ipl;
    accept = gie & req & above;
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int LVL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   evt_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              gie_i,
  input  logic [LVL_W-1:0]  cpu_ipl_i,
  output logic              irq_req_o,
  output logic [LVL_W-1:0]  irq_lvl_o,
  output logic              irq_accept_o
);
  logic [NSRC-1:0] status_q;
  logic [NSRC-1:0] enable_q;
  logic            stat_rd_hit;
  logic            stat_wr_hit;

  irq_status_bank #(.NSRC(NSRC)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_i),
    .rd_hit (stat_rd_hit),
    .wr_hit (stat_wr_hit),
    .wdata  (bus_wdata_i[NSRC-1:0]),
    .status (status_q)
  );

  irq_ctrl_regs #(.NSRC(NSRC), .LVL_W(LVL_W), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (bus_wr_i),
    .rd          (bus_rd_i),
    .addr        (bus_addr_i),
    .wdata       (bus_wdata_i),
    .status      (status_q),
    .req         (irq_req_o),
    .enable      (enable_q),
    .level       (irq_lvl_o),
    .rdata       (bus_rdata_o),
    .stat_rd_hit (stat_rd_hit),
    .stat_wr_hit (stat_wr_hit)
  );

  irq_req_gen #(.NSRC(NSRC)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_q),
    .enable (enable_q),
    .req    (irq_req_o)
  );

  irq_accept #(.LVL_W(LVL_W)) u_acc (
    .gie     (gie_i),
    .req     (irq_req_o),
    .level   (irq_lvl_o),
    .cpu_ipl (cpu_ipl_i),
    .accept  (irq_accept_o)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NSRC  = 8,
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  evt,
  input logic [NSRC-1:0]  status,
  input logic [NSRC-1:0]  enable,
  input logic             req,
  input logic [LVL_W-1:0] lvl,
  input logic             gie,
  input logic             accept,
  input logic             wr_stat
);
  // R1: request is the registered OR of pending-and-enabled
  p_req_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req == |($past(status) & $past(enable)));

  // R3: every pulsed source is pending one edge later
  p_evt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status & $past(evt)) == $past(evt));

  // R3: no pending bit appears without its event
  p_no_spont_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~$past(status) & ~$past(evt)) == '0);

  // R4: a pending bit only falls after a status write
  p_clear_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~status & $past(status)) != '0) |-> $past(wr_stat));

  // R8: acceptance needs flag, request and a nonzero level
  p_accept_needs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (gie && req && (lvl != '0)));

  // R9: request held while an enabled source remains pending
  p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ((status & enable) != '0)) |=> req);
endmodule

bind irq_aggregator irq_aggregator_chk #(.NSRC(NSRC), .LVL_W(LVL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt     (evt_i),
  .status  (status_q),
  .enable  (enable_q),
  .req     (irq_req_o),
  .lvl     (irq_lvl_o),
  .gie     (gie_i),
  .accept  (irq_accept_o),
  .wr_stat (stat_wr_hit)
);

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       gie = 1'b0;
  logic [2:0] ipl = '0;
  logic       req;
  logic [2:0] lvl;
  logic       acc;

  int  checks = 0;
  int  errs = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .gie_i(gie), .cpu_ipl_i(ipl), .irq_req_o(req), .irq_lvl_o(lvl),
    .irq_accept_o(acc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); evt = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic clear_all();
    logic [7:0] d;
    bus_read(2'd0, d);
    bus_write(2'd0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pats [6];
    pats = '{8'h00, 8'h01, 8'h80, 8'h5A, 8'hFF, 8'h24};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), d);
      chk("R2 reset read", {24'h0, d}, 32'h0);
    end
    chk("R2 reset req", {31'h0, req}, 32'h0);
    chk("R2 reset accept", {31'h0, acc}, 32'h0);

    // R3 events set status; writes of 1 neither set nor clear
    pulse(8'h05);
    bus_read(2'd0, d);
    chk("R3 event set", {24'h0, d}, 32'h05);
    bus_write(2'd0, 8'hFF);
    bus_read(2'd0, d);
    chk("R3 write ones", {24'h0, d}, 32'h05);
    clear_all();

    // R1 sweep: every enable value against several pending patterns
    foreach (pats[p]) begin
      clear_all();
      pulse(pats[p]);
      bus_read(2'd0, d);
      chk("R3 pattern set", {24'h0, d}, {24'h0, pats[p]});
      for (int e = 0; e < 256; e++) begin
        bus_write(2'd1, 8'(e));
        @(negedge clk);
        chk("R1 or of and", {31'h0, req}, {31'h0, |(pats[p] & 8'(e))});
      end
    end
    bus_write(2'd1, 8'h00);
    clear_all();

    // R4 clear without prior read is ignored
    pulse(8'h10);
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, d);
    chk("R4 unread clear ignored", {24'h0, d}, 32'h10);
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, d);
    chk("R4 read then clear", {24'h0, d}, 32'h00);

    // R5 event beats clear in the same cycle
    pulse(8'h02);
    bus_read(2'd0, d);
    @(negedge clk); wr = 1'b1; addr = 2'd0; wdata = 8'h00; evt = 8'h02;
    @(negedge clk); wr = 1'b0; evt = '0;
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, d);
    chk("R5 set wins, mark dropped", {24'h0, d}, 32'h02);
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, d);
    chk("R5 cleared after reread", {24'h0, d}, 32'h00);

    // R6 request bit read-only
    bus_write(2'd1, 8'h01);
    pulse(8'h01);
    @(negedge clk);
    bus_read(2'd2, d);
    chk("R6 ctrl shows req", {24'h0, d}, 32'h08);
    bus_write(2'd2, 8'h00);
    @(negedge clk);
    chk("R6 write 0 ignored", {31'h0, req}, 32'h1);
    bus_write(2'd2, 8'hFF);
    bus_read(2'd2, d);
    chk("R11 ctrl upper bits zero", {24'h0, d}, 32'h0F);
    chk("R11 level output", {29'h0, lvl}, 32'h7);
    clear_all();
    @(negedge clk);
    bus_read(2'd2, d);
    chk("R6 write 1 ignored", {24'h0, d}, 32'h07);
    bus_read(2'd3, d);
    chk("R11 spare reads zero", {24'h0, d}, 32'h00);

    // R8 acceptance sweep, request low then high
    for (int r = 0; r < 2; r++) begin
      if (r == 1) begin
        pulse(8'h01);
        @(negedge clk);
      end
      for (int l = 0; l < 8; l++) begin
        bus_write(2'd2, 8'(l));
        for (int g = 0; g < 2; g++) begin
          for (int c = 0; c < 8; c++) begin
            gie = 1'(g); ipl = 3'(c);
            #1;
            chk("R8 accept", {31'h0, acc}, {31'h0, (g == 1) && (r == 1) && (l > c)});
          end
        end
      end
    end

    // R7 acceptance changes nothing
    bus_write(2'd2, 8'h05);
    gie = 1'b1; ipl = 3'd0;
    repeat (4) @(negedge clk);
    chk("R7 accept high", {31'h0, acc}, 32'h1);
    chk("R7 req held", {31'h0, req}, 32'h1);
    bus_read(2'd0, d);
    chk("R7 status held", {24'h0, d}, 32'h01);
    gie = 1'b0;
    clear_all();

    // R9 overlapping sources keep request high
    bus_write(2'd1, 8'h03);
    pulse(8'h01);
    @(negedge clk);
    chk("R9 first source", {31'h0, req}, 32'h1);
    pulse(8'h02);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 second source no drop", {31'h0, req}, 32'h1);
    end
    bus_read(2'd0, d);
    bus_write(2'd0, 8'hFE);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 partial clear no drop", {31'h0, req}, 32'h1);
    end
    bus_read(2'd0, d);
    chk("R9 remaining status", {24'h0, d}, 32'h02);
    clear_all();
    bus_write(2'd1, 8'h00);

    // R10 enabling a pending source raises request one clock later
    pulse(8'h40);
    repeat (3) @(negedge clk);
    chk("R10 masked", {31'h0, req}, 32'h0);
    bus_write(2'd1, 8'h40);
    chk("R10 not yet", {31'h0, req}, 32'h0);
    @(negedge clk);
    chk("R10 raised", {31'h0, req}, 32'h1);
    bus_read(2'd1, d);
    chk("R10 enable readback", {24'h0, d}, 32'h40);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule